// File: doc/BRIEF.md
# Packed Pixel Format Expander

This block sits behind a framebuffer fetch engine. It takes a stream of 32-bit memory words and turns it into a stream of 32-bit ARGB pixels, one pixel per accepted output cycle. A plane control word selects how the bytes are read: 16, 24 or 32 bits per pixel, the channel layout inside a pixel, a byte reversal of each fetched word, where alpha sits in the 32-bit formats, and whether an 8-bit alpha uses the full 0..255 scale or the half scale.

Bytes from the fetched words enter a small byte FIFO. A pixel leaves as soon as the FIFO holds enough bytes for one pixel. Packed 24-bit pixels straddle word boundaries, so three words yield four pixels. The fetch side marks the last word of each scan line. Any bytes left over at that point that do not form a whole pixel are discarded, so that the next line starts on a word boundary. The control word must stay unchanged while a line is in flight.

Top module: `pixel_unpacker`

## Requirements
- R1: After reset, no pixel is offered (outValid low) and a word can be taken at once (inReady high).
- R2: Format code (ctrlWord bits 4:0) 2 is a 32-bit pixel with an unused byte, emitted with alpha 0xFF. Code 5 is 32-bit with 8-bit alpha. With the alpha-switch bit (bit 6) clear, alpha or the unused byte is in bits 31:24 and R,G,B are in 23:16, 15:8, 7:0. With bit 6 set, R,G,B are in 31:24, 23:16, 15:8 and alpha is in 7:0. Bit 6 affects only codes 2 and 5.
- R3: When bit 23 is set, the four bytes of every input word are reversed (byte 0 becomes byte 3) before unpacking. This applies to all codes. Together with bit 6 it gives the blue-first 32-bit layouts.
- R4: Codes 0, 6 and 7 are 16 bits per pixel. Each word carries two pixels, low half first. Code 0 is R5 G6 B5 from the top bits down, with alpha 0xFF.
- R5: Code 6 is A1 R5 G5 B5, where the alpha bit becomes 0x00 or 0xFF. Code 7 is A4 R4 G4 B4. Every channel narrower than 8 bits is widened by copying its top bits into the freed low bits.
- R6: Codes 1 and 4 are 24 bits per pixel, taken from the byte stream in order, with byte 0 of a word first and the first byte as the pixel's low byte. Three words give four pixels. Code 1 is R8 G8 B8 with alpha 0xFF. Code 4 is A8 in bits 23:16 followed by R5 G6 B5.
- R7: For codes 4 and 5, when bit 5 is set, the 8-bit alpha passes unchanged. When bit 5 is clear, alpha values of 128 and above become 255 and a smaller value a becomes 2a. Bit 5 has no effect on other codes.
- R8: A word presented with inLast ends a line. The last whole pixel of that line carries outLast. Leftover bytes that do not form a whole pixel are dropped, and the next line's first pixel starts at byte 0 of its first word.
- R9: Codes 3 and 8 to 31 use one pixel per word and emit 0x00000000.
- R10: While outValid is high and outReady is low, outPixel and outValid hold and inReady is low. With outReady held high, 32-bit formats sustain one pixel per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ctrlWord | input | 32 | Plane control word (format, alpha scale, alpha switch, byte reversal) |
| inValid | input | 1 | Input word is valid |
| inReady | output | 1 | Block takes the input word this cycle |
| inData | input | 32 | Fetched framebuffer word |
| inLast | input | 1 | Input word is the last of a scan line |
| outValid | output | 1 | A pixel is offered |
| outReady | input | 1 | Consumer takes the pixel this cycle |
| outPixel | output | 32 | Pixel as alpha, red, green, blue from the top byte down |
| outLast | output | 1 | Pixel is the last whole pixel of the line |

## Verification
The bench targets the 24-bit packing across word boundaries. A wrong byte-FIFO shift garbles every pixel after the first, and a wrong residue flush at line end shifts the whole next line by one or two bytes. It probes the half-scale alpha edges at 127, 128 and 0xC0, where an unsaturated scale would wrap to small values. It checks that byte reversal and alpha switching combine into the blue-first layouts, where a swapped order would exchange red and blue. Under back-pressure it looks for a design that keeps taking words while a pixel is stalled, which would overrun the FIFO and lose pixels.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
  parameter int unsigned WORD_BYTES = 4;
  localparam int unsigned WORD_W = 8 * WORD_BYTES;
  localparam int unsigned BUF_BYTES = 2 * WORD_BYTES;
  localparam int unsigned BUF_W = 8 * BUF_BYTES;
  localparam int unsigned CNT_W = $clog2(BUF_BYTES) + 1;
  localparam int unsigned PIX_W = 32;

  localparam int unsigned ALPHA_FULL_BIT = 5;
  localparam int unsigned ALPHA_SWITCH_BIT = 6;
  localparam int unsigned BYTE_SWAP_BIT = 23;

  localparam logic [4:0] CODE_RGB565 = 5'd0;
  localparam logic [4:0] CODE_RGB888 = 5'd1;
  localparam logic [4:0] CODE_XRGB32 = 5'd2;
  localparam logic [4:0] CODE_ARGB8565 = 5'd4;
  localparam logic [4:0] CODE_ARGB8888 = 5'd5;
  localparam logic [4:0] CODE_ARGB1555 = 5'd6;
  localparam logic [4:0] CODE_ARGB4444 = 5'd7;

  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
    logic [CNT_W-1:0] base;
  } strobe_t;

  function automatic logic [CNT_W-1:0] pixelBytes(input logic [4:0] code);
    case (code)
      CODE_RGB565, CODE_ARGB1555, CODE_ARGB4444: pixelBytes = CNT_W'(2);
      CODE_RGB888, CODE_ARGB8565:                pixelBytes = CNT_W'(3);
      default:                                   pixelBytes = CNT_W'(4);
    endcase
  endfunction

  function automatic logic [7:0] widen5(input logic [4:0] v);
    widen5 = {v, v[4:2]};
  endfunction

  function automatic logic [7:0] widen6(input logic [5:0] v);
    widen6 = {v, v[5:4]};
  endfunction

  function automatic logic [7:0] widen4(input logic [3:0] v);
    widen4 = {v, v};
  endfunction

  function automatic logic [7:0] scaleAlpha(input logic [7:0] a, input logic full);
    if (full)      scaleAlpha = a;
    else if (a[7]) scaleAlpha = 8'hFF;
    else           scaleAlpha = {a[6:0], 1'b0};
  endfunction
endpackage

// File: rtl/pxu_ctrl.sv
module pxu_ctrl
  import pxu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [4:0] fmtCode,
  input  logic       inValid,
  input  logic       inLast,
  input  logic       outReady,
  output logic       inReady,
  output logic       outValid,
  output logic       outLast,
  output strobe_t    strobe
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] bpp;
  logic [CNT_W-1:0] afterPop;
  logic lastPending;
  logic lastPix;
  logic pop;
  logic flush;
  logic push;

  always_comb begin
    bpp      = pixelBytes(fmtCode);
    outValid = (cnt >= bpp);
    lastPix  = lastPending && (cnt < (bpp << 1));
    outLast  = outValid && lastPix;
    pop      = outValid && outReady;
    flush    = pop && lastPix;
    if (flush)    afterPop = '0;
    else if (pop) afterPop = cnt - bpp;
    else          afterPop = cnt;
    inReady  = (afterPop < bpp);
    push     = inValid && inReady;
    strobe.push  = push;
    strobe.pop   = pop;
    strobe.flush = flush;
    strobe.base  = afterPop;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt         <= '0;
      lastPending <= 1'b0;
    end else begin
      cnt <= afterPop + (push ? CNT_W'(WORD_BYTES) : CNT_W'(0));
      if (push)       lastPending <= inLast;
      else if (flush) lastPending <= 1'b0;
    end
  end

  // R6: byte FIFO never holds more than it can store
  always_comb begin
    a_r6_fifo_bound: assert (!rstN || cnt < CNT_W'(BUF_BYTES));
  end

  a_r10_valid_holds: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);

  a_r10_no_take_when_stalled: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !inReady);

  a_r8_line_end_drains: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outLast && !(inValid && inReady)) |=> !outValid);
endmodule

// File: rtl/pxu_datapath.sv
module pxu_datapath
  import pxu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [WORD_W-1:0] inData,
  input  logic [4:0]        fmtCode,
  input  logic              alphaFull,
  input  logic              alphaSwitch,
  input  logic              byteSwap,
  output logic [PIX_W-1:0]  outPixel
);
  logic [WORD_W-1:0] swapped;
  logic [BUF_W-1:0]  stash;
  logic [BUF_W-1:0]  stashNext;
  logic [CNT_W-1:0]  bpp;
  logic [31:0]       raw;

  for (genvar i = 0; i < WORD_BYTES; i++) begin : g_swap
    assign swapped[8*i +: 8] = byteSwap ? inData[8*(WORD_BYTES-1-i) +: 8] : inData[8*i +: 8];
  end

  always_comb begin
    bpp = pixelBytes(fmtCode);
    if (strobe.flush)    stashNext = '0;
    else if (strobe.pop) stashNext = stash >> {bpp, 3'b000};
    else                 stashNext = stash;
    if (strobe.push)
      stashNext = stashNext | (BUF_W'(swapped) << {strobe.base, 3'b000});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stash <= '0;
    else       stash <= stashNext;
  end

  assign raw = stash[31:0];

  always_comb begin
    case (fmtCode)
      CODE_RGB565:
        outPixel = {8'hFF, widen5(raw[15:11]), widen6(raw[10:5]), widen5(raw[4:0])};
      CODE_ARGB1555:
        outPixel = {{8{raw[15]}}, widen5(raw[14:10]), widen5(raw[9:5]), widen5(raw[4:0])};
      CODE_ARGB4444:
        outPixel = {widen4(raw[15:12]), widen4(raw[11:8]), widen4(raw[7:4]), widen4(raw[3:0])};
      CODE_RGB888:
        outPixel = {8'hFF, raw[23:0]};
      CODE_ARGB8565:
        outPixel = {scaleAlpha(raw[23:16], alphaFull), widen5(raw[15:11]),
                    widen6(raw[10:5]), widen5(raw[4:0])};
      CODE_XRGB32:
        outPixel = alphaSwitch ? {8'hFF, raw[31:8]} : {8'hFF, raw[23:0]};
      CODE_ARGB8888:
        outPixel = alphaSwitch ? {scaleAlpha(raw[7:0], alphaFull), raw[31:8]}
                               : {scaleAlpha(raw[31:24], alphaFull), raw[23:0]};
      default:
        outPixel = '0;
    endcase
  end
endmodule

// File: rtl/pixel_unpacker.sv
module pixel_unpacker
  import pxu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       ctrlWord,
  input  logic              inValid,
  output logic              inReady,
  input  logic [WORD_W-1:0] inData,
  input  logic              inLast,
  output logic              outValid,
  input  logic              outReady,
  output logic [PIX_W-1:0]  outPixel,
  output logic              outLast
);
  strobe_t    strobe;
  logic [4:0] fmtCode;
  logic       unusedCtrlBits;

  assign fmtCode = ctrlWord[4:0];
  assign unusedCtrlBits = ^{ctrlWord[31:BYTE_SWAP_BIT+1], ctrlWord[BYTE_SWAP_BIT-1:ALPHA_SWITCH_BIT+1]};

  pxu_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .fmtCode  (fmtCode),
    .inValid  (inValid),
    .inLast   (inLast),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .outLast  (outLast),
    .strobe   (strobe)
  );

  pxu_datapath u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .inData      (inData),
    .fmtCode     (fmtCode),
    .alphaFull   (ctrlWord[ALPHA_FULL_BIT]),
    .alphaSwitch (ctrlWord[ALPHA_SWITCH_BIT]),
    .byteSwap    (ctrlWord[BYTE_SWAP_BIT]),
    .outPixel    (outPixel)
  );

  a_r10_pixel_stable: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> $stable(outPixel));

  a_r2_opaque_no_alpha: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && (fmtCode == CODE_RGB565 || fmtCode == CODE_RGB888 || fmtCode == CODE_XRGB32))
      |-> (outPixel[31:24] == 8'hFF));

  a_r9_undefined_black: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && (fmtCode == 5'd3 || fmtCode > CODE_ARGB4444)) |-> (outPixel == '0));
endmodule

// File: tb/pixel_unpacker_bench.sv
module pixel_unpacker_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN;
  logic [31:0] ctrlWord;
  logic        inValid, inReady, inLast;
  logic [31:0] inData;
  logic        outValid, outReady, outLast;
  logic [31:0] outPixel;

  pixel_unpacker u_pixel_unpacker (
    .clk(clk), .rstN(rstN), .ctrlWord(ctrlWord),
    .inValid(inValid), .inReady(inReady), .inData(inData), .inLast(inLast),
    .outValid(outValid), .outReady(outReady), .outPixel(outPixel), .outLast(outLast)
  );

  int nChecks = 0;
  int nFails = 0;
  logic [31:0] wq[64];
  bit          lq[64];
  int          nw;
  logic [31:0] eq[128];
  bit          elq[128];
  int          ne;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int bppOf(logic [4:0] c);
    if (c == 0 || c == 6 || c == 7) return 2;
    if (c == 1 || c == 4) return 3;
    return 4;
  endfunction

  function automatic logic [7:0] a8(logic [7:0] a, bit full);
    if (full) return a;
    if (a >= 8'd128) return 8'hFF;
    return a * 2;
  endfunction

  function automatic logic [31:0] model(logic [31:0] cw, logic [31:0] raw);
    logic [31:0] p;
    case (cw[4:0])
      5'd0: p = {8'hFF, raw[15:11], raw[15:13], raw[10:5], raw[10:9], raw[4:0], raw[4:2]};
      5'd1: p = {8'hFF, raw[23:0]};
      5'd2: p = cw[6] ? {8'hFF, raw[31:8]} : {8'hFF, raw[23:0]};
      5'd4: p = {a8(raw[23:16], cw[5]), raw[15:11], raw[15:13], raw[10:5], raw[10:9], raw[4:0], raw[4:2]};
      5'd5: p = cw[6] ? {a8(raw[7:0], cw[5]), raw[31:8]} : {a8(raw[31:24], cw[5]), raw[23:0]};
      5'd6: p = {raw[15] ? 8'hFF : 8'h00, raw[14:10], raw[14:12], raw[9:5], raw[9:7], raw[4:0], raw[4:2]};
      5'd7: p = {raw[15:12], raw[15:12], raw[11:8], raw[11:8], raw[7:4], raw[7:4], raw[3:0], raw[3:0]};
      default: p = 32'h0;
    endcase
    return p;
  endfunction

  task automatic clearQ();
    nw = 0;
  endtask

  task automatic addW(logic [31:0] w, bit l);
    wq[nw] = w;
    lq[nw] = l;
    nw++;
  endtask

  task automatic buildExp(logic [31:0] cw);
    logic [7:0] bq[256];
    int nb = 0;
    int bpp = bppOf(cw[4:0]);
    ne = 0;
    for (int i = 0; i < nw; i++) begin
      logic [31:0] w = cw[23] ? {wq[i][7:0], wq[i][15:8], wq[i][23:16], wq[i][31:24]} : wq[i];
      for (int b = 0; b < 4; b++) begin
        bq[nb] = w[8*b +: 8];
        nb++;
      end
      if (lq[i] || i == nw - 1) begin
        int np = nb / bpp;
        for (int p = 0; p < np; p++) begin
          logic [31:0] raw = 32'h0;
          for (int k = 0; k < bpp; k++) raw[8*k +: 8] = bq[p*bpp + k];
          eq[ne]  = model(cw, raw);
          elq[ne] = (p == np - 1);
          ne++;
        end
        nb = 0;
      end
    end
  endtask

  task automatic runStream(string req, logic [31:0] cw, bit stallMode);
    int wi = 0;
    int k = 0;
    int guard = 0;
    buildExp(cw);
    ctrlWord = cw;
    while ((k < ne || wi < nw) && guard < 2000) begin
      inValid  = (wi < nw);
      inData   = (wi < nw) ? wq[wi] : 32'h0;
      inLast   = (wi < nw) ? lq[wi] : 1'b0;
      outReady = stallMode ? (guard % 3 != 0) : 1'b1;
      @(negedge clk);
      if (outValid && !outReady) check("R10 input held off while stalled", {31'b0, inReady}, 32'h0);
      if (outValid && outReady) begin
        if (k < ne) begin
          check(req, outPixel, eq[k]);
          check("R8 line end marker", {31'b0, outLast}, {31'b0, elq[k]});
        end else begin
          check("R8 no extra pixel", {31'b0, outValid}, 32'h0);
        end
        k++;
      end
      if (inValid && inReady) wi++;
      @(posedge clk);
      #1;
      guard++;
    end
    if (guard >= 2000) check("stream completes", 32'(k), 32'(ne));
    inValid  = 1'b0;
    outReady = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R8 nothing left after line", {31'b0, outValid}, 32'h0);
    @(posedge clk);
    #1;
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1 outValid after reset", {31'b0, outValid}, 32'h0);
    check("R1 inReady after reset", {31'b0, inReady}, 32'h1);
  endtask

  task automatic test32();
    clearQ(); addW(32'h11223344, 0); addW(32'hA5FF0001, 1);
    runStream("R2 code 2 alpha high", 32'h02, 0);
    clearQ(); addW(32'h11223344, 1);
    runStream("R2 code 2 alpha switched", 32'h42, 0);
    clearQ(); addW(32'h80A0B0C0, 0); addW(32'h01020304, 1);
    runStream("R2 code 5 full range", 32'h25, 0);
    clearQ(); addW(32'h11223380, 1);
    runStream("R2 code 5 alpha low", 32'h65, 0);
  endtask

  task automatic testSwap();
    clearQ(); addW(32'hAABBCCDD, 1);
    runStream("R3 blue-first opaque", 32'h0080_0042, 0);
    clearQ(); addW(32'h40302010, 1);
    runStream("R3 blue-first alpha", 32'h0080_0065, 0);
    clearQ(); addW(32'h1234ABCD, 1);
    runStream("R3 reversed 16-bit", 32'h0080_0000, 0);
  endtask

  task automatic test16();
    clearQ(); addW(32'hF80007E0, 0); addW(32'h001F8410, 1);
    runStream("R4 565 two per word", 32'h00, 0);
    clearQ(); addW(32'h80007FFF, 0); addW(32'h2A5595AA, 1);
    runStream("R5 1555", 32'h06, 0);
    clearQ(); addW(32'hF0A5125F, 1);
    runStream("R5 4444", 32'h07, 0);
  endtask

  task automatic test24();
    clearQ(); addW(32'h33221100, 0); addW(32'h77665544, 0); addW(32'hBBAA9988, 1);
    runStream("R6 888 packed", 32'h01, 0);
    clearQ(); addW(32'h40F81F07, 0); addW(32'hC0E0FF80, 0); addW(32'h7F123456, 1);
    runStream("R6 8565 packed full", 32'h24, 0);
    clearQ(); addW(32'h40F81F07, 0); addW(32'hC0E0FF80, 0); addW(32'h7F123456, 1);
    runStream("R7 8565 half scale", 32'h04, 0);
  endtask

  task automatic testAlpha();
    clearQ(); addW(32'h40112233, 0); addW(32'h80112233, 0); addW(32'hC0112233, 0); addW(32'h7F112233, 1);
    runStream("R7 8888 half scale", 32'h05, 0);
    clearQ(); addW(32'h8000FFFF, 1);
    runStream("R7 range bit ignored on 1555", 32'h26, 0);
  endtask

  task automatic testLines();
    clearQ(); addW(32'h03020100, 0); addW(32'h07060504, 1);
    addW(32'h13121110, 0); addW(32'h17161514, 0); addW(32'h1B1A1918, 1);
    runStream("R8 24-bit residue drop", 32'h01, 0);
    clearQ(); addW(32'hF800001F, 1); addW(32'h07E0FFFF, 1);
    runStream("R8 single-word lines", 32'h00, 0);
    clearQ(); addW(32'h80FFFFFF, 1); addW(32'h40000000, 1);
    runStream("R8 one pixel lines", 32'h24, 0);
  endtask

  task automatic testUndefined();
    clearQ(); addW(32'hFFFFFFFF, 0); addW(32'h12345678, 1);
    runStream("R9 code 3 black", 32'h03, 0);
    clearQ(); addW(32'hDEADBEEF, 1);
    runStream("R9 code 31 black", 32'h1F, 0);
  endtask

  task automatic testStall();
    clearQ(); addW(32'h1111F800, 0); addW(32'h22220841, 0); addW(32'h3333FFFF, 1);
    runStream("R10 565 under stall", 32'h00, 1);
    clearQ(); addW(32'h33221100, 0); addW(32'h77665544, 0); addW(32'hBBAA9988, 1);
    runStream("R10 888 under stall", 32'h01, 1);
    clearQ(); addW(32'hCAFEF00D, 0); addW(32'h0BADBEEF, 1);
    runStream("R10 code 5 under stall", 32'h25, 1);
  endtask

  task automatic testRate();
    int got = 0;
    ctrlWord = 32'h02;
    inValid  = 1'b1;
    inLast   = 1'b0;
    inData   = 32'h00ABCDEF;
    outReady = 1'b1;
    for (int c = 0; c < 8; c++) begin
      if (c == 7) inLast = 1'b1;
      @(negedge clk);
      if (c > 0 && outValid) got++;
      @(posedge clk);
      #1;
    end
    inValid = 1'b0;
    check("R10 one pixel per cycle", 32'(got), 32'd7);
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    #(4 * 150000);
    nFails++;
    $display("FAIL watchdog actual %0d expected %0d", 150000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; ctrlWord = 32'h0; inValid = 1'b0; inData = 32'h0; inLast = 1'b0; outReady = 1'b0;
    repeat (3) @(posedge clk);
    testReset();
    rstN = 1'b1;
    @(posedge clk);
    #1;
    test32();
    testSwap();
    test16();
    test24();
    testAlpha();
    testLines();
    testUndefined();
    testStall();
    testRate();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule